// File: doc/BRIEF.md
# Fan Drive Ramp-Rate Limiter

This block sits between whatever produces a fan drive request and the register that sets PWM duty. It holds the drive setting actually applied to the fan. When slew limiting is in force, that setting changes only on an update tick. On each tick it moves toward the requested target by no more than a programmable maximum step. The target may come from a closed-loop speed algorithm, a lookup table or a manual write, and all three are handled the same way.

Two conditions turn limiting on: the closed-loop algorithm being active, or a separate ramp-enable input. When neither holds, the drive follows the target on the next clock. When the closed-loop algorithm runs with its configuration at default, the step size is ignored and the drive jumps to the target on each tick. A step of zero also means no limit. The step register can be written through a small write port. Software can lock it, and the lock stays set until reset.

Top module: `fan_ramp_limiter`

## Requirements
- R1: After reset the drive output is 0 and the step readback is 0x10 (a step of 16).
- R2: A write that is not locked stores write-data bits 5:0 as the maximum step. The readback returns that value in bits 5:0, and bits 7:6 always read as 0.
- R3: While limiting is in force and the step is in use, an update tick with |target - drive| greater than the step moves the drive by exactly the step toward the target, on the clock edge that samples the tick.
- R4: While limiting is in force, an update tick with |target - drive| at most the step sets the drive equal to the target.
- R5: While limiting is in force, the drive does not change on any clock without an update tick.
- R6: With closed-loop inactive and ramp-enable low, the drive equals the target sampled one clock earlier, whether or not a tick is present.
- R7: Closed-loop active enables limiting even when ramp-enable is low.
- R8: With closed-loop active and its default-configuration flag high, the step is ignored: a tick sets the drive to the target. Clocks without a tick still hold the drive.
- R9: A step of 0 means no limit: while limiting is in force, a tick sets the drive to the target.
- R10: Once lock is pulsed, step writes have no effect until reset, including a write in the same cycle as the lock pulse. The lock stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| target | input | 8 | Requested drive setting |
| upd_tick | input | 1 | One-cycle update-period pulse |
| loop_active | input | 1 | Closed-loop speed algorithm is running |
| loop_dflt_cfg | input | 1 | Closed-loop configuration is at default (step ignored) |
| ramp_en | input | 1 | Enables limiting when closed loop is inactive |
| step_wr | input | 1 | Write strobe for the step register |
| step_wdata | input | 8 | Write data, bits 5:0 used |
| lock_set | input | 1 | Pulse to lock the step register |
| step_rd | output | 8 | Step register readback |
| drive | output | 8 | Applied drive setting |

## Verification
The bench ramps up and down across the full 0 to 255 range. In the last step the remainder is smaller than the step, and a design that overshoots or stops one step short would leave the drive off the target. It holds inputs for several clocks with no tick, to catch a limiter that moves without a tick. It checks both ways of enabling limiting, because a design that keys only on ramp-enable would jump straight to the target under closed loop. It tests the step-ignored and zero-step cases, to catch a design that freezes the drive. It also sends a write in the same cycle as the lock pulse and further writes after it, to catch a lock that takes effect one cycle late or that reset fails to clear.

// File: rtl/fan_ramp_limiter.sv
module fan_ramp_limiter #(
  parameter int DW       = 8,
  parameter int SW       = 6,
  parameter int STEP_RST = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] target,
  input  logic          upd_tick,
  input  logic          loop_active,
  input  logic          loop_dflt_cfg,
  input  logic          ramp_en,
  input  logic          step_wr,
  input  logic [DW-1:0] step_wdata,
  input  logic          lock_set,
  output logic [DW-1:0] step_rd,
  output logic [DW-1:0] drive
);
  localparam int PADW = DW - SW;

  logic [SW-1:0] step_q;
  logic          lock_q;
  logic [DW-1:0] drive_q, drive_d;

  wire          lim_on = loop_active | ramp_en;
  wire          no_lim = (loop_active & loop_dflt_cfg) | (step_q == '0);
  wire          going_up = target > drive_q;
  wire [DW-1:0] gap    = going_up ? target - drive_q : drive_q - target;
  wire [DW-1:0] step_w = {{PADW{1'b0}}, step_q};
  wire          clip   = !no_lim && (gap > step_w);

  always_comb begin
    drive_d = drive_q;
    if (!lim_on)
      drive_d = target;
    else if (upd_tick) begin
      if (!clip)
        drive_d = target;
      else if (going_up)
        drive_d = drive_q + step_w;
      else
        drive_d = drive_q - step_w;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive_q <= '0;
      step_q  <= SW'(STEP_RST);
      lock_q  <= 1'b0;
    end else begin
      drive_q <= drive_d;
      lock_q  <= lock_q | lock_set;
      if (step_wr && !lock_q && !lock_set)
        step_q <= step_wdata[SW-1:0];
    end
  end

  assign drive   = drive_q;
  assign step_rd = step_w;
endmodule

// File: rtl/fan_ramp_limiter_chk.sv
module fan_ramp_limiter_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] target,
  input logic          upd_tick,
  input logic          loop_active,
  input logic          loop_dflt_cfg,
  input logic          ramp_en,
  input logic [DW-1:0] step_rd,
  input logic [DW-1:0] drive,
  input logic          locked
);
  wire lim = loop_active | ramp_en;
  wire [DW:0] up_reach = {1'b0, drive} + {1'b0, step_rd};

  assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lim && !upd_tick) |=> (drive == $past(drive)));

  assert_follow_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lim) |=> (drive == $past(target)));

  assert_full_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lim && upd_tick && !(loop_active && loop_dflt_cfg) && step_rd != '0 &&
     {1'b0, target} > up_reach) |=> ({1'b0, drive} == $past(up_reach)));

  assert_lock_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(step_rd));

  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_rd[DW-1:6] == '0);
endmodule

bind fan_ramp_limiter fan_ramp_limiter_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .target(target), .upd_tick(upd_tick),
  .loop_active(loop_active), .loop_dflt_cfg(loop_dflt_cfg), .ramp_en(ramp_en),
  .step_rd(step_rd), .drive(drive), .locked(lock_q)
);

// File: tb/fan_ramp_limiter_tb.sv
module fan_ramp_limiter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [7:0] target = 0, step_wdata = 0;
  logic upd_tick = 0, loop_active = 0, loop_dflt_cfg = 0, ramp_en = 0;
  logic step_wr = 0, lock_set = 0;
  logic [7:0] step_rd, drive;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fan_ramp_limiter dut_i (
    .clk(clk), .rst_n(rst_n), .target(target), .upd_tick(upd_tick),
    .loop_active(loop_active), .loop_dflt_cfg(loop_dflt_cfg), .ramp_en(ramp_en),
    .step_wr(step_wr), .step_wdata(step_wdata), .lock_set(lock_set),
    .step_rd(step_rd), .drive(drive)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic tick();
    upd_tick = 1;
    cyc();
    upd_tick = 0;
  endtask

  task automatic wr_step(input logic [7:0] v);
    step_wr = 1; step_wdata = v;
    cyc();
    step_wr = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    cyc(2);
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 drive", drive, 8'd0);
    chk("R1 step", step_rd, 8'h10);
  endtask

  task automatic t_write();
    wr_step(8'hC5);
    chk("R2 masked", step_rd, 8'h05);
    wr_step(8'd10);
    chk("R2 write", step_rd, 8'd10);
  endtask

  task automatic t_ramp(input logic [7:0] tgt, input int stp);
    int m;
    target = tgt;
    m = drive;
    cyc(3);
    chk("R5 hold", drive, 8'(m));
    while (m != tgt) begin
      if (tgt > m) m = (tgt - m > stp) ? m + stp : tgt;
      else         m = (m - tgt > stp) ? m - stp : tgt;
      tick();
      chk((m == tgt) ? "R4 final" : "R3 step", drive, 8'(m));
      cyc(1);
      chk("R5 hold", drive, 8'(m));
    end
  endtask

  task automatic t_limited();
    ramp_en = 1;
    t_ramp(8'd100, 10);
    t_ramp(8'd105, 10);
    t_ramp(8'd3, 10);
    wr_step(8'd63);
    t_ramp(8'd255, 63);
    t_ramp(8'd0, 63);
  endtask

  task automatic t_off();
    ramp_en = 0; loop_active = 0;
    target = 8'd7;
    cyc();
    chk("R6 follow", drive, 8'd7);
    target = 8'd222;
    cyc();
    chk("R6 follow", drive, 8'd222);
    target = 8'd7;
    cyc();
  endtask

  task automatic t_loop();
    loop_active = 1; loop_dflt_cfg = 0; ramp_en = 0;
    target = 8'd200;
    cyc(2);
    chk("R7 hold", drive, 8'd7);
    tick();
    chk("R7 step", drive, 8'd70);
    loop_dflt_cfg = 1;
    target = 8'd0;
    cyc(2);
    chk("R8 hold", drive, 8'd70);
    tick();
    chk("R8 ignored", drive, 8'd0);
    loop_active = 0; loop_dflt_cfg = 0;
  endtask

  task automatic t_zero();
    ramp_en = 1;
    wr_step(8'd0);
    target = 8'd250;
    cyc(2);
    chk("R9 hold", drive, 8'd0);
    tick();
    chk("R9 unlimited", drive, 8'd250);
  endtask

  task automatic t_lock();
    wr_step(8'd9);
    step_wr = 1; step_wdata = 8'd20; lock_set = 1;
    cyc();
    step_wr = 0; lock_set = 0;
    chk("R10 same cycle", step_rd, 8'd9);
    wr_step(8'd30);
    chk("R10 locked", step_rd, 8'd9);
    cyc(3);
    wr_step(8'd31);
    chk("R10 sticky", step_rd, 8'd9);
    do_reset();
    chk("R10 reset", step_rd, 8'h10);
    wr_step(8'd12);
    chk("R10 unlocked", step_rd, 8'd12);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_write();
    t_limited();
    t_off();
    t_loop();
    t_zero();
    t_lock();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule